// File: doc/BRIEF.md
# Dual-Lane Top-K Distance Selector

This block picks the eight smallest partial distances, each with its path tag, out of a stream of 16 to 96 candidates. The candidates arrive on two independent lanes. Each lane feeds its own bounded insertion list, which takes one candidate per clock and keeps only its eight best entries. When the final beat has been taken, an eight-cycle merge interleaves the two sorted lists into one ascending list of eight.

A sort opens with a one-cycle `start_i` pulse, which empties both lists. Candidate beats follow, and `last_i` marks the cycle that carries the final beats. With candidates split evenly across the lanes, the ranked list is ready after N/2 + 8 cycles: 16 cycles for 16 candidates and 56 cycles for 96. Each distance is cut to a shorter sort key by dropping its low-order bits.

Top module: `topk_dual_sorter`

## Requirements
- R1: The sort key of a candidate is the top KEY_W bits of its DIST_W-bit distance, bits [DIST_W-1:DIST_W-KEY_W]. The reported key is exactly this truncated value.
- R2: After a sort, `best_key_o` holds the KEEP smallest keys of all accepted candidates in ascending order, with slot 0 in the least significant KEY_W bits.
- R3: When keys are equal on one lane, the candidate that arrived earlier ranks first. A key that equals the worst held key of a full list is discarded.
- R4: When keys are equal across the lanes, every lane-a entry ranks ahead of the lane-b entries.
- R5: Each tag stays with its key, and `best_tag_o` slot i carries the tag of `best_key_o` slot i.
- R6: `done_o` is high for exactly one cycle per sort. It rises right after the eighth rising edge that follows the edge accepting the `last_i` beat.
- R7: Counting the edge that accepts the first candidate beat as edge 1, `done_o` is seen after edge N/2 + 8 for N candidates split evenly over the lanes.
- R8: Valid beats and `last_i` presented between the final beat and `done_o` have no effect on the result.
- R9: `start_i` empties both lists, so no entry from an earlier sort appears in a later result.
- R10: Out of reset, `done_o` is low, every key slot holds all ones and every tag slot holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a sort and empties both lists |
| last_i | input | 1 | This cycle carries the final candidate beats |
| a_vld_i | input | 1 | Lane a candidate valid |
| a_dist_i | input | DIST_W | Lane a distance |
| a_tag_i | input | TAG_W | Lane a path tag |
| b_vld_i | input | 1 | Lane b candidate valid |
| b_dist_i | input | DIST_W | Lane b distance |
| b_tag_i | input | TAG_W | Lane b path tag |
| done_o | output | 1 | One-cycle pulse when the ranked list is valid |
| best_key_o | output | KEEP*KEY_W | Ranked keys, slot 0 is the smallest |
| best_tag_o | output | KEEP*TAG_W | Tags matching the ranked keys |

## Verification
The bench uses the default parameters: KEEP = 8, a 24-bit distance cut to a 16-bit key, and 8-bit tags that encode the lane and the arrival index. Because the tag order follows lane and then arrival order, one reference sort on key and tag predicts every tie order. Run lengths of 16 and 96 reach both latency bounds. Runs with all-equal keys, with ties only in the low bits, and with all-ones distances exercise the tie and discard rules. Beats injected during the merge and back-to-back sorts cover the ignore and clear behaviour.

// File: rtl/topk_pkg.sv
package topk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_MERGE   = 2'd2
  } sort_st_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/topk_insert_unit.sv
module topk_insert_unit #(
  parameter int unsigned KEEP  = 8,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned TAG_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        vld_i,
  input  logic [KEY_W-1:0]            key_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [KEEP-1:0][KEY_W-1:0]  key_o,
  output logic [KEEP-1:0][TAG_W-1:0]  tag_o
);
  logic [KEEP-1:0][KEY_W-1:0] key_q, key_d, key_sh;
  logic [KEEP-1:0][TAG_W-1:0] tag_q, tag_d, tag_sh;
  logic [KEEP-1:0]            occ_q, occ_d, occ_sh;
  logic [KEEP-1:0]            lt, lt_up;

  // entry from the slot above, slot 0 takes the new candidate
  assign key_sh[0] = key_i;
  assign tag_sh[0] = tag_i;
  assign occ_sh[0] = 1'b1;
  for (genvar i = 1; i < KEEP; i++) begin : g_shift
    assign key_sh[i] = key_q[i-1];
    assign tag_sh[i] = tag_q[i-1];
    assign occ_sh[i] = occ_q[i-1];
  end

  // strict compare keeps earlier equal keys ahead
  always_comb begin
    for (int i = 0; i < KEEP; i++) lt[i] = !occ_q[i] || (key_i < key_q[i]);
  end
  assign lt_up = {lt[KEEP-2:0], 1'b0};

  always_comb begin
    for (int i = 0; i < KEEP; i++) begin
      if (!lt[i]) begin
        key_d[i] = key_q[i];
        tag_d[i] = tag_q[i];
        occ_d[i] = occ_q[i];
      end else if (lt_up[i]) begin
        key_d[i] = key_sh[i];
        tag_d[i] = tag_sh[i];
        occ_d[i] = occ_sh[i];
      end else begin
        key_d[i] = key_i;
        tag_d[i] = tag_i;
        occ_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '1;
      tag_q <= '0;
      occ_q <= '0;
    end else if (clr_i) begin
      key_q <= '1;
      tag_q <= '0;
      occ_q <= '0;
    end else if (vld_i) begin
      key_q <= key_d;
      tag_q <= tag_d;
      occ_q <= occ_d;
    end
  end

  assign key_o = key_q;
  assign tag_o = tag_q;

  logic sorted_w;
  always_comb begin
    sorted_w = 1'b1;
    for (int i = 0; i < KEEP - 1; i++)
      if (occ_q[i+1] && (key_q[i] > key_q[i+1])) sorted_w = 1'b0;
  end

  AST_LIST_SORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sorted_w); // R2
  AST_FILL_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q & (occ_q + KEEP'(1))) == '0); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (occ_q == '0)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !vld_i) |=> $stable(key_q)); // R8
endmodule

// File: rtl/topk_merge_unit.sv
module topk_merge_unit #(
  parameter int unsigned KEEP  = 8,
  parameter int unsigned KEY_W = 16,
  parameter int unsigned TAG_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        abort_i,
  input  logic                        go_i,
  input  logic [KEEP-1:0][KEY_W-1:0]  a_key_i,
  input  logic [KEEP-1:0][TAG_W-1:0]  a_tag_i,
  input  logic [KEEP-1:0][KEY_W-1:0]  b_key_i,
  input  logic [KEEP-1:0][TAG_W-1:0]  b_tag_i,
  output logic                        done_o,
  output logic [KEEP-1:0][KEY_W-1:0]  key_o,
  output logic [KEEP-1:0][TAG_W-1:0]  tag_o
);
  localparam int unsigned IDX_W = $clog2(KEEP);
  localparam int unsigned CNT_W = $clog2(KEEP + 1);

  logic [CNT_W-1:0]           ia_q, ib_q, cnt_q;
  logic                       active_q, done_q;
  logic [KEEP-1:0][KEY_W-1:0] out_key_q;
  logic [KEEP-1:0][TAG_W-1:0] out_tag_q;
  logic                       a_ok, b_ok, take_a;
  logic [KEY_W-1:0]           a_head, b_head, pick_key;
  logic [TAG_W-1:0]           pick_tag;

  assign a_ok   = ia_q < CNT_W'(KEEP);
  assign b_ok   = ib_q < CNT_W'(KEEP);
  assign a_head = a_key_i[ia_q[IDX_W-1:0]];
  assign b_head = b_key_i[ib_q[IDX_W-1:0]];
  // lane a wins ties
  assign take_a   = a_ok && (!b_ok || (a_head <= b_head));
  assign pick_key = take_a ? a_head : b_head;
  assign pick_tag = take_a ? a_tag_i[ia_q[IDX_W-1:0]] : b_tag_i[ib_q[IDX_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      ia_q      <= '0;
      ib_q      <= '0;
      out_key_q <= '1;
      out_tag_q <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      ia_q     <= '0;
      ib_q     <= '0;
    end else if (active_q) begin
      out_key_q[cnt_q[IDX_W-1:0]] <= pick_key;
      out_tag_q[cnt_q[IDX_W-1:0]] <= pick_tag;
      if (take_a) ia_q <= ia_q + 1'b1;
      else        ib_q <= ib_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(KEEP - 1)) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign key_o  = out_key_q;
  assign tag_o  = out_tag_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_POINTER_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (CNT_W'(ia_q + ib_q) == cnt_q)); // R2
  AST_MERGE_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0) |-> (out_key_q[IDX_W'(cnt_q - 1'b1)] <= pick_key)); // R2
  AST_NO_DONE_WHILE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !done_q); // R6
endmodule

// File: rtl/topk_dual_sorter.sv
module topk_dual_sorter #(
  parameter int unsigned KEEP   = 8,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned DIST_W = 24,
  parameter int unsigned TAG_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    last_i,
  input  logic                    a_vld_i,
  input  logic [DIST_W-1:0]       a_dist_i,
  input  logic [TAG_W-1:0]        a_tag_i,
  input  logic                    b_vld_i,
  input  logic [DIST_W-1:0]       b_dist_i,
  input  logic [TAG_W-1:0]        b_tag_i,
  output logic                    done_o,
  output logic [KEEP*KEY_W-1:0]   best_key_o,
  output logic [KEEP*TAG_W-1:0]   best_tag_o
);
  import topk_pkg::*;

  localparam int unsigned DROP_W = DIST_W - KEY_W;

  sort_st_e st_q;
  logic     accept, merge_go, merge_done;

  logic [NUM_LANES-1:0]                        ln_vld;
  logic [NUM_LANES-1:0][DIST_W-1:0]            ln_dist;
  logic [NUM_LANES-1:0][TAG_W-1:0]             ln_tag;
  logic [NUM_LANES-1:0][KEEP-1:0][KEY_W-1:0]   ln_keys;
  logic [NUM_LANES-1:0][KEEP-1:0][TAG_W-1:0]   ln_tags;
  logic [KEEP-1:0][KEY_W-1:0]                  m_key;
  logic [KEEP-1:0][TAG_W-1:0]                  m_tag;

  assign ln_vld  = {b_vld_i, a_vld_i};
  assign ln_dist = {b_dist_i, a_dist_i};
  assign ln_tag  = {b_tag_i, a_tag_i};

  assign accept   = (st_q == ST_COLLECT) && !start_i;
  assign merge_go = accept && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          st_q <= ST_IDLE;
    else if (start_i)                     st_q <= ST_COLLECT;
    else if (merge_go)                    st_q <= ST_MERGE;
    else if (st_q == ST_MERGE && merge_done) st_q <= ST_IDLE;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [KEY_W-1:0] key_w;
    assign key_w = ln_dist[g][DIST_W-1:DROP_W];

    topk_insert_unit #(
      .KEEP (KEEP),
      .KEY_W(KEY_W),
      .TAG_W(TAG_W)
    ) u_ins (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .vld_i (accept && ln_vld[g]),
      .key_i (key_w),
      .tag_i (ln_tag[g]),
      .key_o (ln_keys[g]),
      .tag_o (ln_tags[g])
    );
  end

  topk_merge_unit #(
    .KEEP (KEEP),
    .KEY_W(KEY_W),
    .TAG_W(TAG_W)
  ) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .abort_i(start_i),
    .go_i   (merge_go),
    .a_key_i(ln_keys[0]),
    .a_tag_i(ln_tags[0]),
    .b_key_i(ln_keys[1]),
    .b_tag_i(ln_tags[1]),
    .done_o (merge_done),
    .key_o  (m_key),
    .tag_o  (m_tag)
  );

  assign done_o     = merge_done;
  assign best_key_o = m_key;
  assign best_tag_o = m_tag;

  AST_MERGE_FREEZES_LISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MERGE && !start_i) |=> $stable(ln_keys)); // R8
  AST_DONE_ONLY_FROM_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(merge_done) |-> ($past(st_q) == ST_MERGE)); // R6
  AST_START_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (ln_keys == '1)); // R9
endmodule

// File: tb/sim_topk_dual_sorter.sv
module sim_topk_dual_sorter;
  localparam int KEEP = 8, KEY_W = 16, DIST_W = 24, TAG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, last = 1'b0;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic [DIST_W-1:0] a_dist = '0, b_dist = '0;
  logic [TAG_W-1:0]  a_tag = '0, b_tag = '0;
  logic done;
  logic [KEEP*KEY_W-1:0] best_key;
  logic [KEEP*TAG_W-1:0] best_tag;

  topk_dual_sorter #(.KEEP(KEEP), .KEY_W(KEY_W), .DIST_W(DIST_W), .TAG_W(TAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_i(last),
    .a_vld_i(a_vld), .a_dist_i(a_dist), .a_tag_i(a_tag),
    .b_vld_i(b_vld), .b_dist_i(b_dist), .b_tag_i(b_tag),
    .done_o(done), .best_key_o(best_key), .best_tag_o(best_tag));

  always #10 clk = ~clk; // 50 MHz

  int checks = 0, fails = 0, cyc = 0, first_cyc = 0, exp_lat = 0, dones = 0;
  bit done_prev = 1'b0, finished = 1'b0;
  logic [KEY_W-1:0] exp_key_q[$];
  logic [TAG_W-1:0] exp_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done && done_prev) chk(1'b0, "R6", "done longer than one cycle", 1, 0);
      if (done && !done_prev) begin
        dones++;
        chk((cyc - first_cyc + 1) == exp_lat, "R7", "latency edges",
            cyc - first_cyc + 1, exp_lat);
        for (int s = 0; s < KEEP; s++) begin
          logic [KEY_W-1:0] ek;
          logic [TAG_W-1:0] et;
          ek = exp_key_q.pop_front();
          et = exp_tag_q.pop_front();
          chk(best_key[s*KEY_W +: KEY_W] == ek, "R2", $sformatf("key slot %0d", s),
              best_key[s*KEY_W +: KEY_W], ek);
          chk(best_tag[s*TAG_W +: TAG_W] == et, "R5", $sformatf("tag slot %0d", s),
              best_tag[s*TAG_W +: TAG_W], et);
        end
      end
      done_prev = done;
    end
  end

  function automatic logic [DIST_W-1:0] gen(int mode, int lane, int j);
    case (mode)
      0: return DIST_W'($urandom);
      1: return 24'h123456;                                  // R3 R4 all ties
      2: return DIST_W'((2000 - (j * 2 + lane)) << 8);       // descending
      3: return {8'h00, 6'h00, 2'($urandom % 3), 8'($urandom)}; // R1 ties in kept bits
      4: return '1;                                          // all-ones keys
      default: return DIST_W'(24'h800000 + (j * 2 + lane) * 256);
    endcase
  endfunction

  // driver: builds candidates, pushes expected list, drives the lanes
  task automatic run_sort(input int n, input int mode, input bit inject);
    logic [DIST_W-1:0] d[2][48];
    logic [KEY_W+TAG_W-1:0] rank[96];
    bit used[96];
    int half = n / 2;
    for (int l = 0; l < 2; l++)
      for (int j = 0; j < half; j++) d[l][j] = gen(mode, l, j);
    // R1 R3 R4: rank = {truncated key, lane, arrival index}
    for (int l = 0; l < 2; l++)
      for (int j = 0; j < half; j++) begin
        rank[l*half+j] = {d[l][j][DIST_W-1 -: KEY_W], 1'(l), 7'(j)};
        used[l*half+j] = 1'b0;
      end
    for (int s = 0; s < KEEP; s++) begin
      int best = -1;
      for (int c = 0; c < n; c++)
        if (!used[c] && (best < 0 || rank[c] < rank[best])) best = c;
      used[best] = 1'b1;
      exp_key_q.push_back(rank[best][KEY_W+TAG_W-1:TAG_W]);
      exp_tag_q.push_back(rank[best][TAG_W-1:0]);
    end
    exp_lat = half + KEEP;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int j = 0; j < half; j++) begin
      if (j == 0) first_cyc = cyc + 1;
      a_vld = 1'b1; b_vld = 1'b1;
      a_dist = d[0][j]; b_dist = d[1][j];
      a_tag = {1'b0, 7'(j)}; b_tag = {1'b1, 7'(j)};
      last = (j == half - 1);
      @(negedge clk);
    end
    if (inject) begin // R8: beats during merge must be ignored
      for (int k = 0; k < 3; k++) begin
        a_dist = '0; b_dist = '0; a_tag = 8'h7f; b_tag = 8'hff; last = 1'b1;
        @(negedge clk);
      end
    end
    a_vld = 1'b0; b_vld = 1'b0; last = 1'b0;
    while (dones == 0 || exp_key_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done == 1'b0, "R10", "done after reset", done, 0);
    chk(best_key == '1, "R10", "keys after reset", best_key[63:0], 64'hffffffffffffffff);
    chk(best_tag == '0, "R10", "tags after reset", best_tag, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_sort(16, 0, 1'b0);   // R2 R7 lower latency bound
    run_sort(96, 0, 1'b0);   // R2 R7 upper latency bound
    run_sort(32, 1, 1'b0);   // R3 R4 all equal
    run_sort(40, 2, 1'b0);   // R2 descending arrivals
    run_sort(48, 3, 1'b0);   // R1 R3 truncation ties
    run_sort(24, 4, 1'b0);   // R3 all-ones keys
    run_sort(20, 0, 1'b1);   // R8 injection during merge
    run_sort(16, 2, 1'b0);   // small keys first ...
    run_sort(16, 5, 1'b0);   // R9 ... must not leak into larger-key sort
    run_sort(64, 0, 1'b1);   // R8 R2
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule